// File: doc/BRIEF.md
# Dual-Select Byte-Lane Memory Control

This block is a synthesizable model of the control side of an asynchronous 16-bit word memory. The chip has two chip selects of opposite polarity, an output enable, a write enable and separate enables for the low and high byte lanes. A free-running clock samples every pin once per cycle. The block decodes the sampled controls into one of four modes: standby, selected but quiet, read, and write. In read mode it drives the enabled byte lanes from a small internal array. It has no true bidirectional port. Instead it reports its output as a data word plus one drive-enable per byte lane, and a lane that is not driven reads as zero.

A write window is open while the chip is selected, the write enable is low and at least one lane enable is low. The window closes on the first sampled cycle in which any of these stops being true. The byte-lane mask, the address and the data word that were sampled in the last open cycle are committed at that point, and only the enabled bytes are changed. Addresses wider than the array are reduced to the array's index width.

Top module: `dual_select_mem`

## Requirements
- R1: The lanes are driven only when chipSelN is 0 and chipSel is 1 at the sampling edge. If chipSelN is 1 or chipSel is 0, laneDrive is 00 and no write takes place.
- R2: If lowLaneN and highLaneN are both 1, laneDrive is 00 and no write takes place, whatever the other controls are.
- R3: A selected read (outEnN 0, wrEnN 1) sets laneDrive[0] = !lowLaneN and laneDrive[1] = !highLaneN. Bits 7:0 of dataOut carry the stored low byte and bits 15:8 the stored high byte. An undriven lane reads as 00.
- R4: When the chip is selected with outEnN 1 and wrEnN 1, laneDrive is 00 and the array does not change.
- R5: When the chip is selected with wrEnN 0, laneDrive is 00 whether outEnN is 0 or 1.
- R6: A write changes only the bytes whose lane enable is low (lowLaneN selects bits 7:0, highLaneN selects bits 15:8). Reading the whole word afterwards returns the new bytes merged with the untouched ones.
- R7: The data, address and lane mask committed are those sampled in the last cycle of the write window. Values present earlier in the window are overwritten.
- R8: The window closes at the first of these events: chipSelN rising, chipSel falling, or wrEnN rising. Changes to the data pins after the window has closed are not stored.
- R9: Only the low log2(DEPTH) bits of addr select a word. Addresses that differ only above those bits refer to the same word.
- R10: Outputs change one clock edge after the pins are sampled. During reset and right after it, laneDrive is 00 and dataOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSelN | input | 1 | Chip select, active low |
| chipSel | input | 1 | Chip select, active high |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| lowLaneN | input | 1 | Low byte lane (bits 7:0) enable, active low |
| highLaneN | input | 1 | High byte lane (bits 15:8) enable, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data; undriven lanes are zero |
| laneDrive | output | 2 | Per-lane output drive enable (bit 0 low, bit 1 high) |

## Verification
Reads are tried with low-only, high-only, both and neither lane enabled. These patterns separate a correct lane-to-bit mapping from a swapped or merged one. Writes are tried as full words, as single bytes and with no lane enabled, and each is followed by a full-word read, which shows whether masking kept the neighbouring byte. Writes whose data changes inside the window, or after the window is closed by each of the three closing events, separate commit-at-end from commit-at-start and from commit-after-release. Aliased addresses and the output-disabled and write-with-output-enable cases separate truncation and the suppression of drive from their faulty variants.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int LANE_CNT = 2;
  localparam int LANE_W   = 8;

  typedef enum logic [1:0] {
    MODE_STANDBY,
    MODE_QUIET,
    MODE_READ,
    MODE_WRITE
  } memMode_t;

  typedef struct packed {
    logic                capture;
    logic                commit;
    logic [LANE_CNT-1:0] writeMask;
    logic [LANE_CNT-1:0] driveMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/dsm_control.sv
module dsm_control
  import dsm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipSelN,
  input  logic                chipSel,
  input  logic                outEnN,
  input  logic                wrEnN,
  input  logic [LANE_CNT-1:0] laneEnN,
  output ctrlStrobe_t         strobe
);
  localparam logic [LANE_CNT-1:0] NO_LANE = '1;

  logic                sCsN, sCs, sOeN, sWeN;
  logic [LANE_CNT-1:0] sLaneN;
  logic                prevWin;
  logic [LANE_CNT-1:0] holdMask;
  logic                selected;
  logic                winActive;
  memMode_t            mode;

  // one sampling stage for every control pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sCsN   <= 1'b1;
      sCs    <= 1'b0;
      sOeN   <= 1'b1;
      sWeN   <= 1'b1;
      sLaneN <= NO_LANE;
    end else begin
      sCsN   <= chipSelN;
      sCs    <= chipSel;
      sOeN   <= outEnN;
      sWeN   <= wrEnN;
      sLaneN <= laneEnN;
    end
  end

  assign selected = !sCsN && sCs && (sLaneN != NO_LANE);

  always_comb begin
    if (!selected)      mode = MODE_STANDBY;
    else if (!sWeN)     mode = MODE_WRITE;
    else if (!sOeN)     mode = MODE_READ;
    else                mode = MODE_QUIET;
  end

  assign winActive = (mode == MODE_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWin  <= 1'b0;
      holdMask <= '0;
    end else begin
      prevWin <= winActive;
      if (winActive) holdMask <= ~sLaneN;
    end
  end

  always_comb begin
    strobe.capture   = winActive;
    strobe.commit    = prevWin && !winActive;
    strobe.writeMask = holdMask;
    strobe.driveMask = (mode == MODE_READ) ? ~sLaneN : '0;
  end
endmodule

// File: rtl/dsm_datapath.sv
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANE_CNT*LANE_W-1:0] dataIn,
  input  ctrlStrobe_t                strobe,
  output logic [LANE_CNT*LANE_W-1:0] dataOut,
  output logic [LANE_CNT-1:0]        laneDrive
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int DATA_W = LANE_CNT * LANE_W;

  logic [IDX_W-1:0]  sIdx;
  logic [IDX_W-1:0]  holdIdx;
  logic [DATA_W-1:0] sData;

  generate
    if (ADDR_W > IDX_W) begin : gTrunc
      logic addrUnusedHi;
      assign addrUnusedHi = ^addr[ADDR_W-1:IDX_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sIdx    <= '0;
      sData   <= '0;
      holdIdx <= '0;
    end else begin
      sIdx  <= addr[IDX_W-1:0];
      sData <= dataIn;
      if (strobe.capture) holdIdx <= sIdx;
    end
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] holdByte;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               holdByte <= '0;
      else if (strobe.capture) holdByte <= sData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (strobe.commit && strobe.writeMask[g]) cells[holdIdx] <= holdByte;
    end

    assign dataOut[g*LANE_W +: LANE_W] = strobe.driveMask[g] ? cells[sIdx] : '0;
    assign laneDrive[g] = strobe.driveMask[g];
  end
endmodule

// File: rtl/dual_select_mem.sv
module dual_select_mem
  import dsm_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              chipSel,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic              lowLaneN,
  input  logic              highLaneN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneDrive
);
  ctrlStrobe_t strobe;

  dsm_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .chipSelN (chipSelN),
    .chipSel  (chipSel),
    .outEnN   (outEnN),
    .wrEnN    (wrEnN),
    .laneEnN  ({highLaneN, lowLaneN}),
    .strobe   (strobe)
  );

  dsm_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .dataOut   (dataOut),
    .laneDrive (laneDrive)
  );
endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSelN,
  input logic              chipSel,
  input logic              outEnN,
  input logic              wrEnN,
  input logic              lowLaneN,
  input logic              highLaneN,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       dataIn,
  input logic [15:0]       dataOut,
  input logic [1:0]        laneDrive
);
  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chipSelN) || !$past(chipSel)) |-> (laneDrive == 2'b00));

  // R2
  no_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lowLaneN) && $past(highLaneN)) |-> (laneDrive == 2'b00));

  // R3
  low_lane_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneDrive[0] |-> (!$past(lowLaneN) && !$past(outEnN)));

  // R3
  high_lane_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    laneDrive[1] |-> (!$past(highLaneN) && !$past(outEnN)));

  // R4
  oe_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outEnN) && $past(wrEnN)) |-> (laneDrive == 2'b00));

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEnN) |-> (laneDrive == 2'b00));

  // R3
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!laneDrive[0] |-> (dataOut[7:0] == 8'h00)) and (!laneDrive[1] |-> (dataOut[15:8] == 8'h00)));
endmodule

bind dual_select_mem dsm_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSel(chipSel),
  .outEnN(outEnN), .wrEnN(wrEnN), .lowLaneN(lowLaneN), .highLaneN(highLaneN),
  .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .laneDrive(laneDrive)
);

// File: tb/dual_select_mem_tb_top.sv
`timescale 1ns/1ps
module dual_select_mem_tb_top;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipSelN = 1'b1, chipSel = 1'b0, outEnN = 1'b1, wrEnN = 1'b1;
  logic              lowLaneN = 1'b1, highLaneN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       dataIn = '0;
  logic [15:0]       dataOut;
  logic [1:0]        laneDrive;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  dual_select_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSel(chipSel),
    .outEnN(outEnN), .wrEnN(wrEnN), .lowLaneN(lowLaneN), .highLaneN(highLaneN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .laneDrive(laneDrive)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pins(input logic csN, input logic cs, input logic oeN, input logic weN,
                      input logic loN, input logic hiN, input logic [ADDR_W-1:0] a, input logic [15:0] d);
    chipSelN = csN; chipSel = cs; outEnN = oeN; wrEnN = weN;
    lowLaneN = loN; highLaneN = hiN; addr = a; dataIn = d;
  endtask

  task automatic idle(input int n);
    pins(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, 16'h0);
    repeat (n) @(negedge clk);
  endtask

  // full write window: opens, holds two cycles, closes by write enable
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic loN, input logic hiN, input logic [15:0] d);
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b1, 1'b0, loN, hiN, a, d);
    repeat (2) @(negedge clk);
    wrEnN = 1'b1;
    @(negedge clk);
    idle(2);
  endtask

  task automatic readCheck(input string req, input logic [ADDR_W-1:0] a, input logic loN, input logic hiN);
    logic [15:0] exp;
    exp = model[a[$clog2(DEPTH)-1:0]];
    if (loN) exp[7:0]  = 8'h00;
    if (hiN) exp[15:8] = 8'h00;
    pins(1'b0, 1'b1, 1'b0, 1'b1, loN, hiN, a, 16'hFFFF);
    @(negedge clk);
    check(req, "laneDrive", 32'(laneDrive), 32'({~hiN, ~loN}));
    check(req, "dataOut", 32'(dataOut), 32'(exp));
    idle(1);
  endtask

  task automatic testReset();
    check("R10", "reset laneDrive", 32'(laneDrive), 32'h0);
    check("R10", "reset dataOut", 32'(dataOut), 32'h0);
  endtask

  task automatic testWordWrite();
    doWrite(20'h00010, 1'b0, 1'b0, 16'hA55A); model[16] = 16'hA55A;
    doWrite(20'h00011, 1'b0, 1'b0, 16'h1234); model[17] = 16'h1234;
    readCheck("R3", 20'h00010, 1'b0, 1'b0);
    readCheck("R3", 20'h00011, 1'b0, 1'b1);
    readCheck("R3", 20'h00011, 1'b1, 1'b0);
    readCheck("R2", 20'h00011, 1'b1, 1'b1);
  endtask

  task automatic testLatency();
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00010, 16'h0);
    #2;
    check("R10", "drive before edge", 32'(laneDrive), 32'h0);
    @(negedge clk);
    check("R10", "drive after edge", 32'(laneDrive), 32'h3);
    idle(1);
  endtask

  task automatic testDeselect();
    pins(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00010, 16'h0);
    @(negedge clk);
    check("R1", "cs_n high", 32'(laneDrive), 32'h0);
    pins(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00010, 16'h0);
    @(negedge clk);
    check("R1", "cs low", 32'(laneDrive), 32'h0);
    check("R1", "cs low data", 32'(dataOut), 32'h0);
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00010, 16'hBEEF);
    @(negedge clk);
    check("R4", "oe off", 32'(laneDrive), 32'h0);
    idle(1);
    readCheck("R4", 20'h00010, 1'b0, 1'b0);
  endtask

  task automatic testWriteQuiet();
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00020, 16'h7E57);
    @(negedge clk);
    check("R5", "write with oe low", 32'(laneDrive), 32'h0);
    outEnN = 1'b1;
    @(negedge clk);
    check("R5", "write with oe high", 32'(laneDrive), 32'h0);
    wrEnN = 1'b1;
    @(negedge clk);
    idle(2);
    model[32] = 16'h7E57;
    readCheck("R5", 20'h00020, 1'b0, 1'b0);
  endtask

  task automatic testByteWrites();
    doWrite(20'h00030, 1'b0, 1'b0, 16'h1111); model[48] = 16'h1111;
    doWrite(20'h00030, 1'b0, 1'b1, 16'hEEAB); model[48] = 16'h11AB;
    readCheck("R6", 20'h00030, 1'b0, 1'b0);
    doWrite(20'h00030, 1'b1, 1'b0, 16'hCD77); model[48] = 16'hCDAB;
    readCheck("R6", 20'h00030, 1'b0, 1'b0);
    doWrite(20'h00030, 1'b1, 1'b1, 16'h0000);
    readCheck("R2", 20'h00030, 1'b0, 1'b0);
  endtask

  task automatic testLateData();
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00040, 16'h0A0A);
    @(negedge clk);
    dataIn = 16'h0B0B;
    @(negedge clk);
    dataIn = 16'h0C0C;
    @(negedge clk);
    wrEnN = 1'b1;
    dataIn = 16'h0D0D;
    @(negedge clk);
    idle(2);
    model[64] = 16'h0C0C;
    readCheck("R7", 20'h00040, 1'b0, 1'b0);
  endtask

  task automatic testEndByCsN();
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00050, 16'h5151);
    @(negedge clk);
    chipSelN = 1'b1;
    @(negedge clk);
    dataIn = 16'h9999;
    @(negedge clk);
    wrEnN = 1'b1;
    @(negedge clk);
    idle(2);
    model[80] = 16'h5151;
    readCheck("R8", 20'h00050, 1'b0, 1'b0);
  endtask

  task automatic testEndByCs();
    @(negedge clk);
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00051, 16'h6262);
    @(negedge clk);
    chipSel = 1'b0;
    @(negedge clk);
    dataIn = 16'h8888;
    addr   = 20'h00052;
    @(negedge clk);
    idle(2);
    model[81] = 16'h6262;
    readCheck("R8", 20'h00051, 1'b0, 1'b0);
  endtask

  task automatic testAlias();
    doWrite(20'hABC05, 1'b0, 1'b0, 16'hFACE);
    model[5] = 16'hFACE;
    readCheck("R9", 20'h00005, 1'b0, 1'b0);
    readCheck("R9", 20'h12405, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWordWrite();
    testLatency();
    testDeselect();
    testWriteQuiet();
    testByteWrites();
    testLateData();
    testEndByCsN();
    testEndByCs();
    testAlias();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule